// File: doc/BRIEF.md
# Thermal Hysteresis Clock-Rate Controller

This block decides how fast a downstream application may run based on the junction temperature of the device. Digitized temperature readings arrive from an external sensor front end together with a one-cycle strobe. Each accepted reading is compared against two software-programmable limits, a high limit and a low limit. A reading at or above the high limit asks for the slow rate. A reading below the low limit asks for the full rate. A reading between the limits leaves the current choice unchanged. This hysteresis band keeps the die close to a target temperature without toggling on every reading.

The application keeps its clock. The block only gates it with a clock-enable. At full rate the enable is high on every cycle. At the slow rate it is high on one cycle in every four, so the fast rate is four times the slow one. A free-running modulo-four counter paces the enable. A pending change of rate is applied only at the start of a counter period, so no enable period is ever cut short.

A small register port holds the two limits and a status word. The status word contains a sticky over-temperature flag that software clears by writing a one to it. If the low limit is programmed at or above the high limit, the block stays at the slow rate until the limits become consistent again.

Top module: `thermal_rate_ctrl`

## Requirements
- R1: After synchronous reset the rate is slow, the high limit reads 85, the low limit reads 75, the over-temperature flag is clear and the pacing counter is at zero, so app_ce is high in the first cycle after reset.
- R2: Register address 0 holds the high limit and address 1 holds the low limit. Both are 8-bit two's-complement degrees Celsius. A write with reg_we high loads reg_wdata, and reg_rdata returns the value combinationally for reg_addr.
- R3: A reading accepted while temp_valid is high that is greater than or equal to the high limit (signed compare) requests the slow rate.
- R4: An accepted reading strictly below the low limit requests the full rate.
- R5: An accepted reading that is at least the low limit and below the high limit leaves the requested rate unchanged.
- R6: temp_data is ignored in every cycle in which temp_valid is low.
- R7: At the full rate app_ce is high on every cycle. At the slow rate it is high only when the pacing counter is zero, which is one cycle in four.
- R8: The applied rate changes only on the clock edge where the counter wraps from three to zero. The request used is the one registered before that edge, so app_ce is high in the first cycle of a new rate.
- R9: While the low limit is greater than or equal to the high limit, the rate applied at each wrap is slow, whatever the readings request.
- R10: The over-temperature flag sets on any accepted reading at or above the high limit. A write to address 2 with data bit 1 set clears it, a write with bit 1 clear leaves it unchanged, and a setting reading in the same cycle as a clearing write wins.
- R11: Address 2 reads bit 0 as the applied rate (1 = slow), bit 1 as the over-temperature flag and bit 2 as limits-invalid, with the other bits zero. Address 3 reads zero and writes to it change nothing. slow_mode and over_temp mirror bits 0 and 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst | input | 1 | Synchronous active-high reset |
| temp_valid | input | 1 | Strobe marking a new temperature reading |
| temp_data | input | 8 | Signed temperature reading in degrees Celsius |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 2 | Register address for read and write |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| app_ce | output | 1 | Clock-enable for the application |
| slow_mode | output | 1 | Applied rate, 1 = quarter rate |
| over_temp | output | 1 | Sticky over-temperature flag |

## Verification
Two coincidences matter most. In the first, a hot reading and a software write that clears the flag land in the same cycle. The bench drives both on one clock edge and expects the flag to remain set, because the setting reading wins. In the second, a reading that changes the request lands on the very edge where the counter wraps. The bench places readings at every counter phase and compares app_ce each cycle against a reference model. That model applies a new request only at the next wrap, so a change that came early or a shortened slow period shows up as a mismatch.

// File: rtl/thermal_rate_pkg.sv
package thermal_rate_pkg;

    localparam int TEMP_W = 8;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] ADDR_UPPER  = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_LOWER  = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_STATUS = 2'd2;

    localparam int ST_RATE_BIT = 0;
    localparam int ST_FLAG_BIT = 1;
    localparam int ST_BAD_BIT  = 2;

    typedef logic signed [TEMP_W-1:0] temp_t;

    typedef enum logic {
        RATE_FAST = 1'b0,
        RATE_SLOW = 1'b1
    } rate_e;

    typedef struct packed {
        logic  valid;
        temp_t value;
    } sample_t;

    typedef struct packed {
        logic              en;
        logic [ADDR_W-1:0] addr;
        logic [TEMP_W-1:0] data;
    } reg_wr_t;

    function automatic logic limits_bad(input temp_t lo, input temp_t hi);
        return lo >= hi;
    endfunction

endpackage

// File: rtl/trc_regs.sv
module trc_regs
    import thermal_rate_pkg::*;
#(
    parameter temp_t RST_UPPER = 8'sd85,
    parameter temp_t RST_LOWER = 8'sd75
) (
    input  logic              clk,
    input  logic              rst,
    input  reg_wr_t           wr,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              hot_evt,
    input  rate_e             applied,
    input  logic              thr_bad,
    output temp_t             upper,
    output temp_t             lower,
    output logic              flag,
    output logic [TEMP_W-1:0] rdata
);

    logic clr_req;
    assign clr_req = wr.en && (wr.addr == ADDR_STATUS) && wr.data[ST_FLAG_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            upper <= RST_UPPER;
            lower <= RST_LOWER;
        end else if (wr.en) begin
            case (wr.addr)
                ADDR_UPPER: upper <= temp_t'(wr.data);
                ADDR_LOWER: lower <= temp_t'(wr.data);
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)          flag <= 1'b0;
        else if (hot_evt) flag <= 1'b1;
        else if (clr_req) flag <= 1'b0;
    end

    always_comb begin
        rdata = '0;
        case (rd_addr)
            ADDR_UPPER:  rdata = upper;
            ADDR_LOWER:  rdata = lower;
            ADDR_STATUS: begin
                rdata[ST_RATE_BIT] = (applied == RATE_SLOW);
                rdata[ST_FLAG_BIT] = flag;
                rdata[ST_BAD_BIT]  = thr_bad;
            end
            default: rdata = '0;
        endcase
    end

endmodule

// File: rtl/trc_decide.sv
module trc_decide
    import thermal_rate_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  sample_t smp,
    input  temp_t   upper,
    input  temp_t   lower,
    output rate_e   req,
    output logic    hot_evt,
    output logic    thr_bad
);

    logic want_slow;

    assign hot_evt = smp.valid && (smp.value >= upper);
    assign thr_bad = limits_bad(lower, upper);

    always_ff @(posedge clk) begin
        if (rst) begin
            want_slow <= 1'b1;
        end else if (smp.valid) begin
            if (smp.value >= upper)     want_slow <= 1'b1;
            else if (smp.value < lower) want_slow <= 1'b0;
        end
    end

    assign req = (want_slow || thr_bad) ? RATE_SLOW : RATE_FAST;

endmodule

// File: rtl/trc_rate_gen.sv
module trc_rate_gen
    import thermal_rate_pkg::*;
#(
    parameter int DIV_LOG2 = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  rate_e req,
    output rate_e applied,
    output logic  app_ce
);

    localparam logic [DIV_LOG2-1:0] LAST = '1;
    localparam logic [DIV_LOG2-1:0] STEP = 1;

    logic [DIV_LOG2-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            applied <= RATE_SLOW;
        end else begin
            cnt <= cnt + STEP;
            if (cnt == LAST) applied <= req;
        end
    end

    assign app_ce = (applied == RATE_FAST) || (cnt == '0);

endmodule

// File: rtl/thermal_rate_ctrl.sv
module thermal_rate_ctrl
    import thermal_rate_pkg::*;
#(
    parameter int    DIV_LOG2  = 2,
    parameter temp_t RST_UPPER = 8'sd85,
    parameter temp_t RST_LOWER = 8'sd75
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              temp_valid,
    input  logic [TEMP_W-1:0] temp_data,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [TEMP_W-1:0] reg_wdata,
    output logic [TEMP_W-1:0] reg_rdata,
    output logic              app_ce,
    output logic              slow_mode,
    output logic              over_temp
);

    sample_t smp;
    reg_wr_t wr;
    temp_t   thr_upper;
    temp_t   thr_lower;
    logic    hot_evt;
    logic    thr_bad;
    rate_e   req;
    rate_e   applied;

    assign smp.valid = temp_valid;
    assign smp.value = temp_t'(temp_data);
    assign wr.en     = reg_we;
    assign wr.addr   = reg_addr;
    assign wr.data   = reg_wdata;

    trc_regs #(
        .RST_UPPER(RST_UPPER),
        .RST_LOWER(RST_LOWER)
    ) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr      (wr),
        .rd_addr (reg_addr),
        .hot_evt (hot_evt),
        .applied (applied),
        .thr_bad (thr_bad),
        .upper   (thr_upper),
        .lower   (thr_lower),
        .flag    (over_temp),
        .rdata   (reg_rdata)
    );

    trc_decide u_decide (
        .clk     (clk),
        .rst     (rst),
        .smp     (smp),
        .upper   (thr_upper),
        .lower   (thr_lower),
        .req     (req),
        .hot_evt (hot_evt),
        .thr_bad (thr_bad)
    );

    trc_rate_gen #(
        .DIV_LOG2(DIV_LOG2)
    ) u_rate (
        .clk     (clk),
        .rst     (rst),
        .req     (req),
        .applied (applied),
        .app_ce  (app_ce)
    );

    assign slow_mode = (applied == RATE_SLOW);

endmodule

// File: rtl/trc_checker.sv
module trc_checker
    import thermal_rate_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              app_ce,
    input logic              slow_mode,
    input logic              over_temp,
    input logic              temp_valid,
    input logic [TEMP_W-1:0] temp_data,
    input temp_t             thr_upper,
    input logic              reg_we,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              clr_bit
);

    logic hot_now;
    logic clr_now;
    assign hot_now = temp_valid && (temp_t'(temp_data) >= thr_upper);
    assign clr_now = reg_we && (reg_addr == ADDR_STATUS) && clr_bit;

    p_fast_ce_r7: assert property (@(posedge clk) disable iff (rst)
        !slow_mode |-> app_ce);

    p_slow_gap_r7: assert property (@(posedge clk) disable iff (rst)
        (slow_mode && app_ce) |=> !app_ce);

    p_switch_boundary_r8: assert property (@(posedge clk) disable iff (rst)
        (slow_mode != $past(slow_mode)) |-> app_ce);

    p_hot_flag_r10: assert property (@(posedge clk) disable iff (rst)
        hot_now |=> over_temp);

    p_flag_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (over_temp && !clr_now) |=> over_temp);

endmodule

bind thermal_rate_ctrl trc_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .app_ce     (app_ce),
    .slow_mode  (slow_mode),
    .over_temp  (over_temp),
    .temp_valid (temp_valid),
    .temp_data  (temp_data),
    .thr_upper  (thr_upper),
    .reg_we     (reg_we),
    .reg_addr   (reg_addr),
    .clr_bit    (reg_wdata[1])
);

// File: tb/thermal_rate_ctrl_test.sv
module thermal_rate_ctrl_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       temp_valid = 1'b0;
    logic [7:0] temp_data = '0;
    logic       reg_we = 1'b0;
    logic [1:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       app_ce;
    logic       slow_mode;
    logic       over_temp;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    thermal_rate_ctrl uut (
        .clk(clk), .rst(rst), .temp_valid(temp_valid), .temp_data(temp_data),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .app_ce(app_ce), .slow_mode(slow_mode),
        .over_temp(over_temp)
    );

    typedef struct {
        logic ce;
        logic slow;
        logic flag;
    } exp_t;

    exp_t exp_q[$];

    int               m_cnt;
    logic             m_slow, m_want, m_flag;
    logic signed [7:0] m_up, m_lo;

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    // Reference model built from the requirements; pushes one expected item per edge
    always @(posedge clk) begin
        logic bad, n_want, n_slow, n_flag;
        int   n_cnt;
        if (rst) begin
            m_cnt = 0; m_slow = 1'b1; m_want = 1'b1; m_flag = 1'b0;
            m_up = 8'sd85; m_lo = 8'sd75;
        end else begin
            bad    = (m_lo >= m_up);
            n_want = m_want;
            if (temp_valid) begin
                if ($signed(temp_data) >= m_up)     n_want = 1'b1;
                else if ($signed(temp_data) < m_lo) n_want = 1'b0;
            end
            n_slow = (m_cnt == 3) ? (m_want | bad) : m_slow;
            n_cnt  = (m_cnt + 1) % 4;
            if (temp_valid && ($signed(temp_data) >= m_up)) n_flag = 1'b1;
            else if (reg_we && reg_addr == 2'd2 && reg_wdata[1]) n_flag = 1'b0;
            else n_flag = m_flag;
            if (reg_we && reg_addr == 2'd0) m_up = $signed(reg_wdata);
            if (reg_we && reg_addr == 2'd1) m_lo = $signed(reg_wdata);
            m_want = n_want; m_slow = n_slow; m_cnt = n_cnt; m_flag = n_flag;
        end
        exp_q.push_back('{ce: (m_slow ? (m_cnt == 0) : 1'b1), slow: m_slow, flag: m_flag});
    end

    // Monitor: pops one expected item per cycle, away from the active edge
    always @(negedge clk) begin
        exp_t e;
        if (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            check("R7 R8 app_ce", {7'b0, app_ce}, {7'b0, e.ce});
            check("R3 R4 R5 R9 slow_mode", {7'b0, slow_mode}, {7'b0, e.slow});
            check("R10 over_temp", {7'b0, over_temp}, {7'b0, e.flag});
        end
    end

    task automatic step(input logic tv, input logic [7:0] td,
                        input logic we, input logic [1:0] ad, input logic [7:0] wd);
        @(negedge clk);
        temp_valid = tv; temp_data = td; reg_we = we; reg_addr = ad; reg_wdata = wd;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 8'h00, 1'b0, 2'd0, 8'h00);
    endtask

    task automatic rd(input logic [1:0] ad, input logic [7:0] exp, input string tag);
        @(negedge clk);
        temp_valid = 1'b0; reg_we = 1'b0; reg_addr = ad;
        #1;
        check(tag, reg_rdata, exp);
    endtask

    function automatic logic [7:0] status_exp();
        return {5'b0, (m_lo >= m_up), m_flag, m_slow};
    endfunction

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset values
        rd(2'd0, 8'd85, "R1 high limit");
        rd(2'd1, 8'd75, "R1 low limit");
        rd(2'd2, 8'h01, "R1 status");
        idle(8);                                   // R7 slow pattern
        step(1'b1, 8'd60, 1'b0, 2'd0, 8'h00);      // R4 cold reading
        idle(8);
        rd(2'd2, status_exp(), "R4 R11 status fast");
        step(1'b1, 8'd80, 1'b0, 2'd0, 8'h00);      // R5 inside band
        idle(6);
        rd(2'd2, 8'h00, "R5 hold fast");
        step(1'b0, 8'd120, 1'b0, 2'd0, 8'h00);     // R6 strobe low
        idle(6);
        rd(2'd2, 8'h00, "R6 ignored reading");
        step(1'b1, 8'd85, 1'b0, 2'd0, 8'h00);      // R3 equal to high limit
        idle(6);
        rd(2'd2, 8'h03, "R3 R10 slow and flagged");
        step(1'b0, 8'd0, 1'b1, 2'd2, 8'h00);       // R10 write zero keeps flag
        rd(2'd2, 8'h03, "R10 write zero no effect");
        step(1'b0, 8'd0, 1'b1, 2'd2, 8'h02);       // R10 clear
        rd(2'd2, 8'h01, "R10 cleared");
        step(1'b1, 8'd100, 1'b1, 2'd2, 8'h02);     // R10 set beats clear
        rd(2'd2, 8'h03, "R10 set wins");
        step(1'b0, 8'd0, 1'b1, 2'd2, 8'h02);
        step(1'b0, 8'd0, 1'b1, 2'd1, 8'd90);       // R9 low above high
        step(1'b1, 8'd50, 1'b0, 2'd0, 8'h00);
        idle(9);
        rd(2'd2, 8'h05, "R9 forced slow");
        step(1'b0, 8'd0, 1'b1, 2'd1, 8'd70);       // limits valid again
        idle(9);
        rd(2'd2, 8'h00, "R9 released to fast");
        rd(2'd1, 8'd70, "R2 low limit readback");
        step(1'b0, 8'd0, 1'b1, 2'd0, 8'hF6);       // R2 high = -10
        step(1'b0, 8'd0, 1'b1, 2'd1, 8'hEC);       // R2 low = -20
        rd(2'd0, 8'hF6, "R2 negative high limit");
        step(1'b1, 8'hFB, 1'b0, 2'd0, 8'h00);      // -5 >= -10
        idle(8);
        rd(2'd2, status_exp(), "R2 R3 signed hot");
        step(1'b1, 8'hE7, 1'b0, 2'd0, 8'h00);      // -25 < -20
        idle(8);
        rd(2'd2, status_exp(), "R2 R4 signed cold");
        step(1'b0, 8'd0, 1'b1, 2'd3, 8'hFF);       // R11 unused address
        rd(2'd3, 8'h00, "R11 addr3 reads zero");
        rd(2'd0, 8'hF6, "R11 addr3 write ignored high");
        rd(2'd1, 8'hEC, "R11 addr3 write ignored low");
        step(1'b0, 8'd0, 1'b1, 2'd0, 8'd40);
        step(1'b0, 8'd0, 1'b1, 2'd1, 8'd30);
        // R8: readings at every counter phase, compared cycle by cycle
        for (int k = 0; k < 40; k++) begin
            step(1'b1, ((k % 3) == 0) ? 8'd45 : (((k % 3) == 1) ? 8'd20 : 8'd35),
                 1'b0, 2'd0, 8'h00);
            idle(k % 5);
        end
        idle(8);
        rd(2'd2, status_exp(), "R8 R11 final status");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule